// File: doc/BRIEF.md
# Masked Interrupt Register Bank

This block holds the interrupt state for a four-channel DMA engine. Five interrupt classes exist: transfer done, block done, source-side transaction done, destination-side transaction done, and error. For each class the bank keeps three per-channel bit vectors. A raw status vector latches single-cycle event pulses from the channels. A mask vector enables or blocks each channel's events. A masked status vector is the bitwise AND of the two. All masked status bits, across every class, are ORed into one interrupt line, which is registered.

Software reaches the bank through a plain memory-mapped read/write port. The mask registers use a paired write-enable field. Each mask bit in the low nibble changes only when its partner bit, eight positions higher, is set in the same write. Firmware can therefore mask or unmask one channel without reading the register first. Each class also has a write-one-to-clear register that acknowledges its raw status bits.

Top module: `irqbank_top`

## Requirements
- R1: After reset every mask and raw status bit is 0, the interrupt output is 0, and every register reads 0.
- R2: A write to the mask register of class k sets mask bit n to write-data bit n, but only when write-data bit n+8 is 1. The mask register of class k is at 0x310 + 8·k, with classes in the order transfer, block, source transaction, destination transaction, error. Mask bits change only on such writes.
- R3: A mask write whose data bits [11:8] are all 0 leaves that mask register unchanged.
- R4: A mask register read returns the mask in bits [3:0]. Every other bit reads 0, and no read returns anything above bit 3.
- R5: An event pulse on evtIn bit k·4+n sets raw bit n of class k at the next clock edge. The bit holds until cleared. Raw status of class k reads at 0x2C0 + 8·k in bits [3:0].
- R6: A write to 0x338 + 8·k clears each raw bit n of class k whose write-data bit n is 1. Zeros in the data have no effect. If an event and a clear hit the same bit in the same cycle, the bit stays set.
- R7: Masked status of class k reads at 0x2E8 + 8·k. It equals raw AND mask for that class, with a mask bit of 1 meaning unmasked.
- R8: irqOut is, one cycle later, the OR of all twenty masked status bits.
- R9: Writes to any address outside the four register groups change nothing. Reads from such addresses return 0, and busRdata is 0 while busRead is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busWrite | input | 1 | Write strobe, one transfer per cycle |
| busRead | input | 1 | Read strobe; data is returned in the same cycle |
| busAddr | input | 12 | Byte address of the transfer |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, combinational from busAddr |
| evtIn | input | 20 | Event pulses, bit k·4+n is class k channel n |
| irqOut | output | 1 | Registered combined interrupt |

## Verification
Directed writes first apply the paired-enable mask pattern. One write sets a single bit. One carries a zero enable field. One enables a bit while writing it to 0. One places garbage in the upper bits. Together these separate a correct per-bit enable from a plain full overwrite, from ignoring the enable field, and from a readback that leaks upper bits. Events and clears are then aimed at the same bit in the same cycle, and the result shows whether set or clear takes priority. A long random phase follows. It mixes sparse events, enable patterns, off-grid addresses such as 0x314, and reads of every register kind. A behavioural model tracks the state and is compared with the read data and irqOut on every cycle, which catches decode aliasing, wrong class indexing and a missing irq pipeline stage.

// File: rtl/irqbank_pkg.sv
package irqbank_pkg;

  localparam int CLASS_CNT = 5;
  localparam int CLASS_IDX_W = $clog2(CLASS_CNT);

  typedef enum logic [1:0] {
    RD_NONE   = 2'd0,
    RD_RAW    = 2'd1,
    RD_MASKED = 2'd2,
    RD_MASK   = 2'd3
  } rdKind_e;

  typedef struct packed {
    logic [CLASS_CNT-1:0]   maskWr;
    logic [CLASS_CNT-1:0]   clrWr;
    rdKind_e                rdKind;
    logic [CLASS_IDX_W-1:0] rdClass;
  } strobes_t;

endpackage

// File: rtl/irqbank_ctrl.sv
module irqbank_ctrl
  import irqbank_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int RAW_BASE  = 'h2C0,
  parameter int STAT_BASE = 'h2E8,
  parameter int MASK_BASE = 'h310,
  parameter int CLR_BASE  = 'h338,
  parameter int STRIDE    = 8
) (
  input  logic              busWrite,
  input  logic              busRead,
  input  logic [ADDR_W-1:0] busAddr,
  output strobes_t          st
);

  always_comb begin
    st = '0;
    st.rdKind = RD_NONE;
    for (int k = 0; k < CLASS_CNT; k++) begin
      if (busWrite && busAddr == ADDR_W'(MASK_BASE + k * STRIDE)) st.maskWr[k] = 1'b1;
      if (busWrite && busAddr == ADDR_W'(CLR_BASE + k * STRIDE))  st.clrWr[k]  = 1'b1;
      if (busRead) begin
        if (busAddr == ADDR_W'(RAW_BASE + k * STRIDE)) begin
          st.rdKind  = RD_RAW;
          st.rdClass = CLASS_IDX_W'(k);
        end
        if (busAddr == ADDR_W'(STAT_BASE + k * STRIDE)) begin
          st.rdKind  = RD_MASKED;
          st.rdClass = CLASS_IDX_W'(k);
        end
        if (busAddr == ADDR_W'(MASK_BASE + k * STRIDE)) begin
          st.rdKind  = RD_MASK;
          st.rdClass = CLASS_IDX_W'(k);
        end
      end
    end
  end

endmodule

// File: rtl/irqbank_dp.sv
module irqbank_dp
  import irqbank_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int DATA_W = 32,
  parameter int WE_LSB = 8,
  localparam int FLAT_W = CLASS_CNT * NUM_CH,
  localparam int WD_W   = WE_LSB + NUM_CH
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobes_t          st,
  input  logic [WD_W-1:0]   wrData,
  input  logic [FLAT_W-1:0] evtIn,
  output logic [DATA_W-1:0] rdData,
  output logic [FLAT_W-1:0] rawBits,
  output logic [FLAT_W-1:0] maskBits,
  output logic              irq
);

  logic [FLAT_W-1:0] statBits;
  logic [NUM_CH-1:0] dataBits;
  logic [NUM_CH-1:0] weBits;
  logic              unusedGap;

  assign dataBits  = wrData[NUM_CH-1:0];
  assign weBits    = wrData[WE_LSB +: NUM_CH];
  assign unusedGap = ^wrData;

  for (genvar k = 0; k < CLASS_CNT; k++) begin : g_class
    logic [NUM_CH-1:0] rawR;
    logic [NUM_CH-1:0] maskR;
    logic [NUM_CH-1:0] clrVec;
    logic [NUM_CH-1:0] enVec;

    assign clrVec = st.clrWr[k]  ? dataBits : '0;
    assign enVec  = st.maskWr[k] ? weBits   : '0;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        rawR  <= '0;
        maskR <= '0;
      end else begin
        rawR  <= (rawR & ~clrVec) | evtIn[k*NUM_CH +: NUM_CH];
        maskR <= (maskR & ~enVec) | (dataBits & enVec);
      end
    end

    assign rawBits[k*NUM_CH +: NUM_CH]  = rawR;
    assign maskBits[k*NUM_CH +: NUM_CH] = maskR;
  end

  assign statBits = rawBits & maskBits;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) irq <= 1'b0;
    else       irq <= |statBits;
  end

  always_comb begin
    rdData = '0;
    for (int k = 0; k < CLASS_CNT; k++) begin
      if (int'(st.rdClass) == k) begin
        case (st.rdKind)
          RD_RAW:    rdData[NUM_CH-1:0] = rawBits[k*NUM_CH +: NUM_CH];
          RD_MASKED: rdData[NUM_CH-1:0] = statBits[k*NUM_CH +: NUM_CH];
          RD_MASK:   rdData[NUM_CH-1:0] = maskBits[k*NUM_CH +: NUM_CH];
          default:   rdData = '0;
        endcase
      end
    end
  end

endmodule

// File: rtl/irqbank_top.sv
module irqbank_top
  import irqbank_pkg::*;
#(
  parameter int NUM_CH    = 4,
  parameter int ADDR_W    = 12,
  parameter int DATA_W    = 32,
  parameter int WE_LSB    = 8,
  parameter int RAW_BASE  = 'h2C0,
  parameter int STAT_BASE = 'h2E8,
  parameter int MASK_BASE = 'h310,
  parameter int CLR_BASE  = 'h338,
  parameter int STRIDE    = 8,
  localparam int FLAT_W   = CLASS_CNT * NUM_CH,
  localparam int WD_W     = WE_LSB + NUM_CH
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWrite,
  input  logic              busRead,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic [FLAT_W-1:0] evtIn,
  output logic              irqOut
);

  strobes_t          st;
  logic [FLAT_W-1:0] rawBits;
  logic [FLAT_W-1:0] maskBits;
  logic              unusedWdata;

  assign unusedWdata = ^busWdata[DATA_W-1:WD_W];

  irqbank_ctrl #(
    .ADDR_W(ADDR_W), .RAW_BASE(RAW_BASE), .STAT_BASE(STAT_BASE),
    .MASK_BASE(MASK_BASE), .CLR_BASE(CLR_BASE), .STRIDE(STRIDE)
  ) u_ctrl (
    .busWrite(busWrite),
    .busRead (busRead),
    .busAddr (busAddr),
    .st      (st)
  );

  irqbank_dp #(
    .NUM_CH(NUM_CH), .DATA_W(DATA_W), .WE_LSB(WE_LSB)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .st      (st),
    .wrData  (busWdata[WD_W-1:0]),
    .evtIn   (evtIn),
    .rdData  (busRdata),
    .rawBits (rawBits),
    .maskBits(maskBits),
    .irq     (irqOut)
  );

endmodule

// File: rtl/irqbank_chk.sv
module irqbank_chk #(
  parameter int NUM_CH = 4,
  parameter int DATA_W = 32,
  parameter int FLAT_W = 20
) (
  input logic              clk,
  input logic              rstN,
  input logic              busWrite,
  input logic              busRead,
  input logic [DATA_W-1:0] busRdata,
  input logic [FLAT_W-1:0] evtIn,
  input logic [FLAT_W-1:0] rawBits,
  input logic [FLAT_W-1:0] maskBits,
  input logic              irqOut
);

  // R2: mask state moves only on a bus write
  a_r2_mask_needs_write: assert property (@(posedge clk) disable iff (!rstN)
    !busWrite |=> $stable(maskBits));

  // R4: nothing above the channel field is ever returned
  a_r4_upper_bits_zero: assert property (@(posedge clk) disable iff (!rstN)
    busRdata[DATA_W-1:NUM_CH] == '0);

  // R5: every pulsed event is latched at the next edge
  a_r5_event_latched: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((rawBits & $past(evtIn)) == $past(evtIn)));

  // R5: raw bits never rise without an event
  a_r5_no_spurious_set: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((rawBits & ~$past(rawBits) & ~$past(evtIn)) == '0));

  // R8: irq follows the combined masked state by one cycle
  a_r8_irq_follows: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (irqOut == $past(|(rawBits & maskBits))));

  // R9: idle bus returns zero
  a_r9_idle_read_zero: assert property (@(posedge clk) disable iff (!rstN)
    !busRead |-> busRdata == '0);

endmodule

bind irqbank_top irqbank_chk #(
  .NUM_CH(NUM_CH), .DATA_W(DATA_W), .FLAT_W(FLAT_W)
) u_chk (.*);

// File: tb/test_irqbank_top.sv
`timescale 1ns/1ps
module test_irqbank_top;

  localparam int NCH = 4;
  localparam int NCL = 5;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWrite = 1'b0;
  logic        busRead = 1'b0;
  logic [11:0] busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [19:0] evtIn = '0;
  logic        irqOut;

  int vecCnt = 0;
  int badCnt = 0;
  bit done = 1'b0;

  logic [3:0] rawM  [NCL];
  logic [3:0] maskM [NCL];
  logic       irqM = 1'b0;

  always #5 clk = ~clk;

  irqbank_top i_irqbank_top (.*);

  function automatic int rawA(int k);  return 'h2C0 + 8*k; endfunction
  function automatic int statA(int k); return 'h2E8 + 8*k; endfunction
  function automatic int maskA(int k); return 'h310 + 8*k; endfunction
  function automatic int clrA(int k);  return 'h338 + 8*k; endfunction

  function automatic logic [31:0] modelRead(logic rd, logic [11:0] a);
    logic [31:0] v = '0;
    if (rd)
      for (int k = 0; k < NCL; k++) begin
        if (a == 12'(rawA(k)))  v = {28'd0, rawM[k]};
        if (a == 12'(statA(k))) v = {28'd0, rawM[k] & maskM[k]};
        if (a == 12'(maskA(k))) v = {28'd0, maskM[k]};
      end
    return v;
  endfunction

  function automatic string tagFor(logic rd, logic [11:0] a);
    string t = "R9";
    if (rd)
      for (int k = 0; k < NCL; k++) begin
        if (a == 12'(rawA(k)))  t = "R5";
        if (a == 12'(statA(k))) t = "R7";
        if (a == 12'(maskA(k))) t = "R4";
      end
    return t;
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    vecCnt++;
    if (act !== exp) begin
      badCnt++;
      $display("FAIL %s at %0t: actual %h expected %h", tag, $time, act, exp);
    end
  endtask

  // reference model, advanced on every rising edge
  initial for (int k = 0; k < NCL; k++) begin rawM[k] = '0; maskM[k] = '0; end

  always @(posedge clk) begin
    if (!rstN) begin
      irqM = 1'b0;
      for (int k = 0; k < NCL; k++) begin rawM[k] = '0; maskM[k] = '0; end
    end else begin
      irqM = 1'b0;
      for (int k = 0; k < NCL; k++) irqM |= |(rawM[k] & maskM[k]);
      for (int k = 0; k < NCL; k++) begin
        if (busWrite && busAddr == 12'(maskA(k)))
          for (int n = 0; n < NCH; n++)
            if (busWdata[8+n]) maskM[k][n] = busWdata[n];
        if (busWrite && busAddr == 12'(clrA(k)))
          rawM[k] = rawM[k] & ~busWdata[3:0];
        rawM[k] = rawM[k] | evtIn[k*NCH +: NCH];
      end
    end
  end

  // every-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rstN && !done) begin
      check("R8", {31'd0, irqOut}, {31'd0, irqM});
      check(tagFor(busRead, busAddr), busRdata, modelRead(busRead, busAddr));
    end
  end

  task automatic drive(logic w, int wa, logic [31:0] wd, logic r, int ra, logic [19:0] ev);
    @(posedge clk); #1;
    busWrite = w; busWdata = wd; busRead = r; evtIn = ev;
    busAddr = w ? 12'(wa) : 12'(ra);
    if (w && r) busAddr = 12'(wa);
  endtask

  task automatic doWrite(int a, logic [31:0] d);
    drive(1'b1, a, d, 1'b0, 0, '0);
  endtask

  task automatic expectRead(int a, logic [31:0] exp, string tag);
    drive(1'b0, 0, '0, 1'b1, a, '0);
    @(negedge clk);
    check(tag, busRdata, exp);
  endtask

  task automatic finishUp();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vecCnt, badCnt);
    $finish;
  endtask

  initial begin
    #1_000_000;
    badCnt++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishUp();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;

    // R1: reset state
    for (int k = 0; k < NCL; k++) begin
      expectRead(maskA(k), 32'h0, "R1");
      expectRead(rawA(k), 32'h0, "R1");
    end
    check("R1", {31'd0, irqOut}, 32'h0);

    // R2: single-bit set via paired enable
    doWrite(maskA(0), 32'h0101);
    expectRead(maskA(0), 32'h1, "R2");
    // R3: zero enable field leaves mask alone
    doWrite(maskA(0), 32'h00FE);
    expectRead(maskA(0), 32'h1, "R3");
    // R2: enable with data 0 clears only that bit
    doWrite(maskA(1), 32'h0F0A);
    expectRead(maskA(1), 32'hA, "R2");
    doWrite(maskA(1), 32'h0205);
    expectRead(maskA(1), 32'h8, "R2");
    // R4: garbage upper bits never reach readback
    doWrite(maskA(0), 32'hFFFF_F1F1);
    expectRead(maskA(0), 32'h1, "R4");

    // R5 / R7 / R8: events on transfer class channels 0 and 2
    drive(1'b0, 0, '0, 1'b0, 0, 20'h00005);
    expectRead(rawA(0), 32'h5, "R5");
    expectRead(statA(0), 32'h1, "R7");
    check("R8", {31'd0, irqOut}, 32'h1);

    // R6: clear bit 0, then set beats clear on bit 2
    doWrite(clrA(0), 32'h1);
    expectRead(rawA(0), 32'h4, "R6");
    drive(1'b1, clrA(0), 32'h4, 1'b0, 0, 20'h00004);
    expectRead(rawA(0), 32'h4, "R6");
    doWrite(clrA(0), 32'h4);
    expectRead(rawA(0), 32'h0, "R6");

    // R9: off-grid write ignored, off-grid read zero
    doWrite('h314, 32'h0F0F);
    expectRead(maskA(0), 32'h1, "R9");
    expectRead('h314, 32'h0, "R9");
    // R5: error class channel 3 maps to evtIn bit 19
    drive(1'b0, 0, '0, 1'b0, 0, 20'h80000);
    expectRead(rawA(4), 32'h8, "R5");

    // random mix compared by the model each cycle
    for (int i = 0; i < 4000; i++) begin
      int kind = $urandom % 6;
      int k = $urandom % NCL;
      int wa;
      int ra;
      logic [19:0] ev = '0;
      case (kind)
        0: wa = maskA(k);
        1: wa = maskA(k);
        2: wa = clrA(k);
        3: wa = rawA(k);
        4: wa = 'h314 + 8 * ($urandom % 4);
        default: wa = $urandom % 4096;
      endcase
      case ($urandom % 4)
        0: ra = rawA($urandom % NCL);
        1: ra = statA($urandom % NCL);
        2: ra = maskA($urandom % NCL);
        default: ra = $urandom % 4096;
      endcase
      for (int b = 0; b < 20; b++) ev[b] = ($urandom % 16) == 0;
      if ($urandom % 2) drive(1'b1, wa, $urandom, 1'b0, 0, ev);
      else drive(1'b0, 0, '0, ($urandom % 4) != 0, ra, ev);
    end
    @(negedge clk);
    finishUp();
  end

endmodule